// File: doc/BRIEF.md
# Address Translation Fault Reporter

This block sits between a translation lookup port and the processor's exception logic. Each access is presented with a one-cycle request strobe. The block first decides whether address translation is in force. That decision uses the configuration inputs and the virtual-mode bit of the machine status word. It then produces a page-aligned physical address in one of two ways. When translation is off, the address passes through with full permissions. When translation is on and the lookup hits, the address is relocated by the lookup's page bases.

When translation is on and the lookup fails, the block raises a fault. It captures the complete faulting address and builds an exception status word. The low five bits of that word encode both the failure kind (missing entry or permission violation) and whether the access was an instruction fetch. A separate bit marks store accesses. The block tracks a pending fault until the exception logic reports that it was taken. A second failure that arrives while a fault is still pending is reported as a fatal recursive fault, and the first fault's captured values are kept.

Top module: `xfr_top`

## Requirements
- R1: Translation is in force only when `cfg_mmu_present` and `msr_vm` are both 1 and, if `cfg_full_ver` is 1, `cfg_ver_mmu` is also 1; otherwise the access is passed through.
- R2: On a passed-through access, `phys_page` is the request address with its low `PAGE_BITS` (default 12) bits cleared and `pass_thru` is 1; the lookup result is ignored, so no fault is raised even when `lk_hit` is 0.
- R3: On a translated access with `lk_hit` = 1, `phys_page` = `lk_pbase` + (page-aligned address − `lk_vbase`), modulo 2^ADDR_W, and `pass_thru` is 0.
- R4: On a translated access with `lk_hit` = 0 and no fault pending, `fault_stb` is 1 for exactly one cycle and `fault_ear` holds the full unmasked request address.
- R5: A permission failure (`lk_prot` = 1) gives a status code of 17 in `fault_esr[4:0]` for an instruction fetch and 16 for a data access.
- R6: A missing-entry failure (`lk_prot` = 0) gives a status code of 19 in `fault_esr[4:0]` for a fetch and 18 for a data access.
- R7: `req_kind` is encoded 0 = load, 1 = store, 2 = fetch, and 3 is treated as a load. `fault_esr[10]` is 1 exactly when the faulting access was a store, and every other bit outside [4:0] is 0.
- R8: A failure that arrives while `fault_pending` is 1 and `exc_taken` is 0 pulses `fatal_recur` for one cycle. In that case `fault_stb` stays 0 and `fault_ear` and `fault_esr` keep their earlier values.
- R9: `fault_pending` goes to 1 with each reported fault and returns to 0 one cycle after `exc_taken` is 1 with no new fault in that cycle.
- R10: All outputs are registered. `rsp_valid` is 1 exactly one cycle after `req_valid`. Without a request, both strobes are 0 and `phys_page` and `pass_thru` hold their values.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mmu_present | input | 1 | Translation hardware is configured |
| cfg_full_ver | input | 1 | Full version-register set is present |
| cfg_ver_mmu | input | 1 | Version register reports translation in use |
| msr_vm | input | 1 | Virtual-mode bit of the machine status word |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | ADDR_W | Access address |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| lk_hit | input | 1 | Lookup found a usable entry |
| lk_prot | input | 1 | On a failed lookup: 1 permission, 0 missing entry |
| lk_pbase | input | ADDR_W | Physical page base of the matched entry |
| lk_vbase | input | ADDR_W | Virtual page base of the matched entry |
| exc_taken | input | 1 | Exception logic has taken the pending fault |
| rsp_valid | output | 1 | Result registered for the previous request |
| phys_page | output | ADDR_W | Page-aligned physical address |
| pass_thru | output | 1 | Last completed access bypassed translation |
| fault_stb | output | 1 | One-cycle fault report |
| fault_ear | output | ADDR_W | Captured faulting address |
| fault_esr | output | ESR_W | Captured exception status word |
| fault_pending | output | 1 | A reported fault awaits the exception logic |
| fatal_recur | output | 1 | One-cycle fatal recursive-fault report |

## Verification
Every result of a request is due one clock edge after `req_valid` is sampled. This covers `rsp_valid`, `phys_page`, `pass_thru`, both strobes, the captured words and the rise of `fault_pending`. The fall of `fault_pending` is due one edge after `exc_taken`. The bench drives inputs on the falling clock edge and samples at the following falling edge, which is half a period after the edge that loads the registers. It also looks once more one cycle later, to confirm that the strobes have dropped and that held values did not move.

// File: rtl/xfr_pkg.sv
package xfr_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  // bit of the status word flagging a store access
  localparam int ESR_STORE_BIT = 10;
  localparam int CODE_W        = 5;

  // 16 perm/data, 17 perm/fetch, 18 miss/data, 19 miss/fetch
  function automatic logic [CODE_W-1:0] fault_code(input logic is_prot,
                                                   input logic is_fetch);
    logic [CODE_W-1:0] c;
    c    = 5'd16;
    c[1] = ~is_prot;
    c[0] = is_fetch;
    return c;
  endfunction

endpackage

// File: rtl/xfr_mode_sel.sv
module xfr_mode_sel (
  input  logic cfg_mmu_present,
  input  logic cfg_full_ver,
  input  logic cfg_ver_mmu,
  input  logic msr_vm,
  output logic xlat_on
);
  logic unit_usable;

  // a full version-register set may veto the configured unit
  always_comb begin
    unit_usable = cfg_mmu_present;
    if (cfg_full_ver && !cfg_ver_mmu) unit_usable = 1'b0;
    xlat_on = unit_usable & msr_vm;
  end
endmodule

// File: rtl/xfr_addr_calc.sv
module xfr_addr_calc #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              xlat_on,
  input  logic [ADDR_W-1:0] lk_pbase,
  input  logic [ADDR_W-1:0] lk_vbase,
  output logic [ADDR_W-1:0] phys_page
);
  localparam logic [ADDR_W-1:0] OFS_MASK = (ADDR_W'(1) << PAGE_BITS) - ADDR_W'(1);

  function automatic logic [ADDR_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a & ~OFS_MASK;
  endfunction

  function automatic logic [ADDR_W-1:0] relocate(input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] pb,
                                                 input logic [ADDR_W-1:0] vb);
    return pb + (page_of(a) - vb);
  endfunction

  always_comb begin
    if (xlat_on) phys_page = relocate(addr, lk_pbase, lk_vbase);
    else         phys_page = page_of(addr);
  end
endmodule

// File: rtl/xfr_status_gen.sv
module xfr_status_gen
  import xfr_pkg::*;
#(
  parameter int ESR_W = 32
) (
  input  logic             is_prot,
  input  logic [1:0]       kind,
  output logic [ESR_W-1:0] esr_word
);
  logic is_fetch, is_store;

  always_comb begin
    is_fetch = (kind == ACC_FETCH);
    is_store = (kind == ACC_STORE);
    esr_word = '0;
    esr_word[CODE_W-1:0]   = fault_code(is_prot, is_fetch);
    esr_word[ESR_STORE_BIT] = is_store;
  end
endmodule

// File: rtl/xfr_fault_track.sv
module xfr_fault_track (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_ev,
  input  logic exc_taken,
  output logic first_fault,
  output logic recursive,
  output logic pending
);
  logic pending_q;

  always_comb begin
    recursive   = fault_ev & pending_q & ~exc_taken;
    first_fault = fault_ev & ~recursive;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           pending_q <= 1'b0;
    else if (first_fault) pending_q <= 1'b1;
    else if (exc_taken)   pending_q <= 1'b0;
  end

  assign pending = pending_q;

  // R9
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending_q) |-> $past(exc_taken));
endmodule

// File: rtl/xfr_top.sv
module xfr_top
  import xfr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int ESR_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mmu_present,
  input  logic              cfg_full_ver,
  input  logic              cfg_ver_mmu,
  input  logic              msr_vm,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic              lk_hit,
  input  logic              lk_prot,
  input  logic [ADDR_W-1:0] lk_pbase,
  input  logic [ADDR_W-1:0] lk_vbase,
  input  logic              exc_taken,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] phys_page,
  output logic              pass_thru,
  output logic              fault_stb,
  output logic [ADDR_W-1:0] fault_ear,
  output logic [ESR_W-1:0]  fault_esr,
  output logic              fault_pending,
  output logic              fatal_recur
);
  // internal events brought out for the checks
  logic              xlat_on;
  logic [ADDR_W-1:0] page_calc;
  logic [ESR_W-1:0]  esr_calc;
  logic              fault_ev;
  logic              first_fault;
  logic              recursive;

  xfr_mode_sel u_mode (
    .cfg_mmu_present (cfg_mmu_present),
    .cfg_full_ver    (cfg_full_ver),
    .cfg_ver_mmu     (cfg_ver_mmu),
    .msr_vm          (msr_vm),
    .xlat_on         (xlat_on)
  );

  xfr_addr_calc #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_addr (
    .addr      (req_addr),
    .xlat_on   (xlat_on),
    .lk_pbase  (lk_pbase),
    .lk_vbase  (lk_vbase),
    .phys_page (page_calc)
  );

  xfr_status_gen #(.ESR_W(ESR_W)) u_stat (
    .is_prot  (lk_prot),
    .kind     (req_kind),
    .esr_word (esr_calc)
  );

  assign fault_ev = req_valid & xlat_on & ~lk_hit;

  xfr_fault_track u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_ev    (fault_ev),
    .exc_taken   (exc_taken),
    .first_fault (first_fault),
    .recursive   (recursive),
    .pending     (fault_pending)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      phys_page   <= '0;
      pass_thru   <= 1'b0;
      fault_stb   <= 1'b0;
      fault_ear   <= '0;
      fault_esr   <= '0;
      fatal_recur <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      fault_stb   <= first_fault;
      fatal_recur <= recursive;
      if (req_valid && !fault_ev) begin
        phys_page <= page_calc;
        pass_thru <= ~xlat_on;
      end
      if (first_fault) begin
        fault_ear <= req_addr;
        fault_esr <= esr_calc;
      end
    end
  end

  // R10
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));
  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_stb && fatal_recur));
  // R8
  recur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_recur |-> ($stable(fault_ear) && $stable(fault_esr) && fault_pending));
  // R9
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_stb |-> fault_pending);
  // R5
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_stb |-> (fault_esr[4] && fault_esr[3:2] == 2'b00));
  // R7
  store_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_stb |-> (fault_esr[ESR_STORE_BIT] == ($past(req_kind) == ACC_STORE)));
  // R2
  pass_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !msr_vm) |=> !fault_stb && !fatal_recur);
endmodule

// File: tb/xfr_top_bench.sv
module xfr_top_bench;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_mmu_present, cfg_full_ver, cfg_ver_mmu, msr_vm;
  logic req_valid;
  logic [AW-1:0] req_addr;
  logic [1:0] req_kind;
  logic lk_hit, lk_prot;
  logic [AW-1:0] lk_pbase, lk_vbase;
  logic exc_taken;
  logic rsp_valid, pass_thru, fault_stb, fault_pending, fatal_recur;
  logic [AW-1:0] phys_page, fault_ear;
  logic [31:0] fault_esr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xfr_top u_xfr_top (
    .clk(clk), .rst_n(rst_n),
    .cfg_mmu_present(cfg_mmu_present), .cfg_full_ver(cfg_full_ver),
    .cfg_ver_mmu(cfg_ver_mmu), .msr_vm(msr_vm),
    .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind),
    .lk_hit(lk_hit), .lk_prot(lk_prot), .lk_pbase(lk_pbase), .lk_vbase(lk_vbase),
    .exc_taken(exc_taken),
    .rsp_valid(rsp_valid), .phys_page(phys_page), .pass_thru(pass_thru),
    .fault_stb(fault_stb), .fault_ear(fault_ear), .fault_esr(fault_esr),
    .fault_pending(fault_pending), .fatal_recur(fatal_recur)
  );

  typedef struct packed {
    logic [3:0]  cfg;      // mmu, full, vbit, vm
    logic [31:0] addr;
    logic [1:0]  kind;
    logic        hit;
    logic        prot;
    logic [31:0] pbase;
    logic [31:0] vbase;
    logic        e_fault;
    logic [31:0] e_page;
    logic [31:0] e_esr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R1/R2: unit absent, mode bit ignored
    '{4'b0001, 32'h1234_5678, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 32'h1234_5000, 32'h0},
    // R1/R2: virtual mode off
    '{4'b1000, 32'hABCD_EFFF, 2'd1, 1'b0, 1'b1, 32'h0, 32'h0, 1'b0, 32'hABCD_E000, 32'h0},
    // R1/R2: version register vetoes the unit
    '{4'b1101, 32'h0000_1FFF, 2'd2, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_1000, 32'h0},
    // R3: hit with version register agreeing
    '{4'b1111, 32'h0040_3ABC, 2'd0, 1'b1, 1'b0, 32'h8000_0000, 32'h0040_0000, 1'b0, 32'h8000_3000, 32'h0},
    // R3: hit relocating downwards
    '{4'b1001, 32'h2000_0123, 2'd2, 1'b1, 1'b0, 32'h1000_0000, 32'h2000_0000, 1'b0, 32'h1000_0000, 32'h0},
    // R5 load, R5 store, R5 fetch
    '{4'b1001, 32'hDEAD_BEEF, 2'd0, 1'b0, 1'b1, 32'h0, 32'h0, 1'b1, 32'h0, 32'h0000_0010},
    '{4'b1001, 32'h0000_0FF4, 2'd1, 1'b0, 1'b1, 32'h0, 32'h0, 1'b1, 32'h0, 32'h0000_0410},
    '{4'b1001, 32'hC000_0004, 2'd2, 1'b0, 1'b1, 32'h0, 32'h0, 1'b1, 32'h0, 32'h0000_0011},
    // R6 load, R6 store, R6 fetch, R7 kind 3 as load
    '{4'b1001, 32'h5555_AAAA, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 32'h0, 32'h0000_0012},
    '{4'b1011, 32'hFFFF_FFFC, 2'd1, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 32'h0, 32'h0000_0412},
    '{4'b1001, 32'h0000_0000, 2'd2, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 32'h0, 32'h0000_0013},
    '{4'b1001, 32'h7000_0001, 2'd3, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 32'h0, 32'h0000_0012}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 1'b0; exc_taken = 1'b0;
  endtask

  task automatic drive(input vec_t v);
    {cfg_mmu_present, cfg_full_ver, cfg_ver_mmu, msr_vm} = v.cfg;
    req_addr = v.addr; req_kind = v.kind; lk_hit = v.hit; lk_prot = v.prot;
    lk_pbase = v.pbase; lk_vbase = v.vbase; req_valid = 1'b1;
  endtask

  task automatic take_exc();
    exc_taken = 1'b1;
    @(negedge clk);
    exc_taken = 1'b0;
    chk(fault_pending == 1'b0, "R9 clear", 32'(fault_pending), 32'h0);
    chk(fault_stb == 1'b0, "R4 one-cycle", 32'(fault_stb), 32'h0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual %h expected %h", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] held_ear, held_esr, held_page;
    rst_n = 1'b0;
    cfg_mmu_present = 0; cfg_full_ver = 0; cfg_ver_mmu = 0; msr_vm = 0;
    req_addr = '0; req_kind = '0; lk_hit = 0; lk_prot = 0;
    lk_pbase = '0; lk_vbase = '0;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R11
    chk({rsp_valid, pass_thru, fault_stb, fault_pending, fatal_recur} == 5'b0,
        "R11 strobes", 32'({rsp_valid, pass_thru, fault_stb, fault_pending, fatal_recur}), 32'h0);
    chk(phys_page == 0 && fault_ear == 0 && fault_esr == 0, "R11 words",
        phys_page | fault_ear | fault_esr, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      idle_inputs();
      chk(rsp_valid == 1'b1, "R10 rsp", 32'(rsp_valid), 32'h1);
      chk(fault_stb == VECS[i].e_fault, "R4 strobe", 32'(fault_stb), 32'(VECS[i].e_fault));
      if (VECS[i].e_fault) begin
        chk(fault_ear == VECS[i].addr, "R4 ear", fault_ear, VECS[i].addr);
        chk(fault_esr[4:0] == VECS[i].e_esr[4:0], VECS[i].prot ? "R5 code" : "R6 code",
            32'(fault_esr[4:0]), 32'(VECS[i].e_esr[4:0]));
        chk(fault_esr == VECS[i].e_esr, "R7 word", fault_esr, VECS[i].e_esr);
        chk(fault_pending == 1'b1, "R9 set", 32'(fault_pending), 32'h1);
        take_exc();
      end else begin
        chk(phys_page == VECS[i].e_page, VECS[i].hit ? "R3 page" : "R2 page",
            phys_page, VECS[i].e_page);
        chk(pass_thru == !VECS[i].cfg[3] || !VECS[i].cfg[0] ||
            (VECS[i].cfg[2] && !VECS[i].cfg[1]), "R1 mode", 32'(pass_thru),
            32'(!VECS[i].hit));
        chk(pass_thru == !VECS[i].hit, "R2 pass flag", 32'(pass_thru), 32'(!VECS[i].hit));
      end
    end

    // R10: idle cycle holds page and flag, strobes low
    held_page = phys_page;
    @(negedge clk);
    chk(rsp_valid == 0 && fault_stb == 0 && fatal_recur == 0, "R10 idle",
        32'({rsp_valid, fault_stb, fatal_recur}), 32'h0);
    chk(phys_page == held_page, "R10 hold", phys_page, held_page);

    // R8: first fault, then a second without taking the first
    drive('{4'b1001, 32'h0BAD_0001, 2'd1, 1'b0, 1'b1, 32'h0, 32'h0, 1'b1, 32'h0, 32'h410});
    @(negedge clk);
    idle_inputs();
    held_ear = fault_ear; held_esr = fault_esr;
    chk(held_ear == 32'h0BAD_0001, "R4 ear first", held_ear, 32'h0BAD_0001);
    drive('{4'b1001, 32'h0BAD_0002, 2'd2, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 32'h0, 32'h13});
    @(negedge clk);
    idle_inputs();
    chk(fatal_recur == 1'b1, "R8 fatal", 32'(fatal_recur), 32'h1);
    chk(fault_stb == 1'b0, "R8 no strobe", 32'(fault_stb), 32'h0);
    chk(fault_ear == held_ear, "R8 ear kept", fault_ear, held_ear);
    chk(fault_esr == held_esr, "R8 esr kept", fault_esr, held_esr);
    @(negedge clk);
    chk(fatal_recur == 1'b0, "R8 pulse", 32'(fatal_recur), 32'h0);
    chk(fault_pending == 1'b1, "R9 still pending", 32'(fault_pending), 32'h1);
    take_exc();

    // R4: after clearing, a new failure is reported normally
    drive('{4'b1001, 32'h0BAD_0003, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 32'h0, 32'h12});
    @(negedge clk);
    idle_inputs();
    chk(fault_stb == 1'b1 && fault_ear == 32'h0BAD_0003, "R4 after clear",
        fault_ear, 32'h0BAD_0003);
    chk(fault_esr == 32'h12, "R6 after clear", fault_esr, 32'h12);

    // R2: pass-through during a pending fault raises nothing
    drive('{4'b1000, 32'h0000_3456, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_3000, 32'h0});
    @(negedge clk);
    idle_inputs();
    chk(fatal_recur == 0 && fault_stb == 0, "R2 no fault", 32'({fatal_recur, fault_stb}), 32'h0);
    chk(phys_page == 32'h0000_3000, "R2 page pending", phys_page, 32'h0000_3000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule